// File: doc/BRIEF.md
# Four-Output Bridge PWM Generator

This block produces one pulse-width-modulated waveform from a 10-bit time base and routes it onto four output pins, A to D. The time base is an 8-bit period counter extended with two low-order fraction bits, so one PWM period lasts 4*(period+1) clock cycles. The duty value is 10 bits wide and is compared against the full time base. The pulse starts at the beginning of each period and ends when the time base reaches the latched duty value.

A 2-bit mode input selects how the waveform is routed. In single mode only pin A is driven. In half-bridge mode pins A and B form a complementary pair, and each turn-on edge is delayed by a programmable dead-band count. In the two full-bridge directions one pin of the bridge is held on and the diagonal pin carries the modulation. A polarity input sets the active level for each pin pair. Period, duty and mode are captured into shadow registers at each period boundary, so a change never cuts a period short. After enable the block spends one full idle period before it drives any pulse.

Top module: `bridge_pwm`

## Requirements
- R1: While reset is high and afterwards with enable low, every pin sits at its inactive level, which is the matching polarity bit (pins A and C follow bit 0, pins B and D follow bit 1).
- R2: A period lasts 4*(period+1) cycles. In single mode (mode 2'b00), pin A is active for duty cycles of every period.
- R3: A duty value of zero gives no active cycle. A duty value of 4*(period+1) or more keeps the modulated pin active for the whole period.
- R4: In single mode, pins B, C and D stay inactive.
- R5: In half-bridge mode (mode 2'b01), with high time h and period length P, A is active for h minus the dead-band count cycles and B for P minus h minus the dead-band count cycles (each floored at zero), and A and B are never active together. If h is 0, B is active for all P cycles. If h equals P, A is active for all P cycles. C and D stay inactive.
- R6: In forward full-bridge mode (mode 2'b10), A is active for the whole period, D is active for duty cycles, and B and C stay inactive.
- R7: In reverse full-bridge mode (mode 2'b11), C is active for the whole period, B is active for duty cycles, and A and D stay inactive.
- R8: Polarity bit 0 set to 1 makes A and C active-low. Polarity bit 1 set to 1 does the same for B and D. The active-cycle counts of R2 to R7 are unchanged.
- R9: After enable rises, no pin becomes active during the first 4*(period+1)+1 cycles. The first pulse appears on the next cycle.
- R10: A mode change made in the middle of a period takes effect on the pins two cycles after the next period boundary, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable. While low, the time base is held and the shadows follow the inputs |
| period | input | 8 | Period count; a period lasts 4*(period+1) cycles |
| duty | input | 10 | Duty count, compared against the 10-bit time base |
| mode | input | 2 | 00 single, 01 half-bridge, 10 forward, 11 reverse |
| pol | input | 2 | Bit 0: A/C active-low; bit 1: B/D active-low |
| deadband | input | 7 | Turn-on delay in cycles for the half-bridge pair |
| out_a | output | 1 | Pin A |
| out_b | output | 1 | Pin B |
| out_c | output | 1 | Pin C |
| out_d | output | 1 | Pin D |

## Verification
The bench goes after the duty extremes. A design with a compare that is off by one would show one stray active cycle at duty zero, or a one-cycle gap at full duty. In half-bridge mode with a constant waveform, a dead-band counter that does not saturate would chop B periodically. The bench also times the enabled start and a mid-period mode change cycle by cycle. A design without the idle first period, or one that reloads its shadows immediately, would show a partial pulse or a truncated period on the wrong pin.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_HALF   = 2'b01,
        MODE_FWD    = 2'b10,
        MODE_REV    = 2'b11
    } bpwm_mode_e;

    // Pin indices inside the 4-bit active vector
    localparam int PIN_A = 0;
    localparam int PIN_B = 1;
    localparam int PIN_C = 2;
    localparam int PIN_D = 3;

    typedef struct packed {
        bpwm_mode_e mode;
        logic       run;
        logic       pwm;
    } bpwm_tap_t;

    // Map the raw waveform and dead-band qualified phases onto pins.
    function automatic logic [3:0] bpwm_route(
        input bpwm_mode_e m,
        input logic       run,
        input logic       pwm,
        input logic       lead,
        input logic       trail
    );
        logic [3:0] r;
        r = '0;
        if (run) begin
            case (m)
                MODE_SINGLE: r[PIN_A] = pwm;
                MODE_HALF: begin
                    r[PIN_A] = lead;
                    r[PIN_B] = trail;
                end
                MODE_FWD: begin
                    r[PIN_A] = 1'b1;
                    r[PIN_D] = pwm;
                end
                default: begin
                    r[PIN_C] = 1'b1;
                    r[PIN_B] = pwm;
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase
    import bpwm_pkg::*;
#(
    parameter int PER_W  = 8,
    parameter int FRAC_W = 2,
    localparam int BASE_W = PER_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PER_W-1:0]  period,
    input  logic [BASE_W-1:0] duty,
    input  bpwm_mode_e        mode,
    output logic [BASE_W-1:0] base,
    output logic [PER_W-1:0]  per_s,
    output bpwm_tap_t         tap
);

    logic [BASE_W-1:0] base_r;
    logic [BASE_W-1:0] duty_s;
    logic [PER_W-1:0]  per_r;
    bpwm_mode_e        mode_s;
    logic              run_r;
    logic              wrap;

    assign wrap = (base_r == {per_r, {FRAC_W{1'b1}}});

    always_ff @(posedge clk) begin
        if (rst) begin
            base_r <= '0;
            per_r  <= '0;
            duty_s <= '0;
            mode_s <= MODE_SINGLE;
            run_r  <= 1'b0;
        end else if (!en) begin
            base_r <= '0;
            run_r  <= 1'b0;
            per_r  <= period;
            duty_s <= duty;
            mode_s <= mode;
        end else if (wrap) begin
            base_r <= '0;
            run_r  <= 1'b1;
            per_r  <= period;
            duty_s <= duty;
            mode_s <= mode;
        end else begin
            base_r <= base_r + BASE_W'(1);
        end
    end

    assign base     = base_r;
    assign per_s    = per_r;
    assign tap.mode = mode_s;
    assign tap.run  = run_r;
    assign tap.pwm  = run_r && (base_r < duty_s);

endmodule

// File: rtl/bpwm_deadband.sv
module bpwm_deadband
    import bpwm_pkg::*;
#(
    parameter int DB_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  bpwm_tap_t       tap_in,
    input  logic [DB_W-1:0] deadband,
    output bpwm_tap_t       tap_q,
    output logic            lead_on,
    output logic            trail_on
);

    logic [DB_W-1:0] since_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q      <= '{mode: MODE_SINGLE, run: 1'b0, pwm: 1'b0};
            since_edge <= '0;
        end else begin
            tap_q <= tap_in;
            if (tap_in.pwm != tap_q.pwm) begin
                since_edge <= '0;
            end else if (since_edge != {DB_W{1'b1}}) begin
                since_edge <= since_edge + DB_W'(1);
            end
        end
    end

    assign lead_on  =  tap_q.pwm && (since_edge >= deadband);
    assign trail_on = !tap_q.pwm && (since_edge >= deadband);

endmodule

// File: rtl/bpwm_steer.sv
module bpwm_steer
    import bpwm_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bpwm_tap_t         tap_q,
    input  logic              lead_on,
    input  logic              trail_on,
    output logic [N_PINS-1:0] act_q
);

    logic [3:0] route;

    assign route = bpwm_route(tap_q.mode, tap_q.run, tap_q.pwm, lead_on, trail_on);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                act_q[i] <= 1'b0;
            end else begin
                act_q[i] <= route[i];
            end
        end
    end

endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm
    import bpwm_pkg::*;
#(
    parameter int PER_W  = 8,
    parameter int FRAC_W = 2,
    parameter int DB_W   = 7,
    localparam int BASE_W = PER_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PER_W-1:0]  period,
    input  logic [BASE_W-1:0] duty,
    input  logic [1:0]        mode,
    input  logic [1:0]        pol,
    input  logic [DB_W-1:0]   deadband,
    output logic              out_a,
    output logic              out_b,
    output logic              out_c,
    output logic              out_d
);

    bpwm_tap_t         tap_raw;
    bpwm_tap_t         tap_q;
    logic [BASE_W-1:0] base;
    logic [PER_W-1:0]  per_s;
    logic              lead_on;
    logic              trail_on;
    logic [3:0]        act_q;
    bpwm_mode_e        mode_q;
    logic              run_q;

    bpwm_timebase #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .period (period),
        .duty   (duty),
        .mode   (bpwm_mode_e'(mode)),
        .base   (base),
        .per_s  (per_s),
        .tap    (tap_raw)
    );

    bpwm_deadband #(.DB_W(DB_W)) u_db (
        .clk      (clk),
        .rst      (rst),
        .tap_in   (tap_raw),
        .deadband (deadband),
        .tap_q    (tap_q),
        .lead_on  (lead_on),
        .trail_on (trail_on)
    );

    bpwm_steer #(.N_PINS(4)) u_st (
        .clk      (clk),
        .rst      (rst),
        .tap_q    (tap_q),
        .lead_on  (lead_on),
        .trail_on (trail_on),
        .act_q    (act_q)
    );

    assign mode_q = tap_q.mode;
    assign run_q  = tap_q.run;

    assign out_a = act_q[PIN_A] ^ pol[0];
    assign out_c = act_q[PIN_C] ^ pol[0];
    assign out_b = act_q[PIN_B] ^ pol[1];
    assign out_d = act_q[PIN_D] ^ pol[1];

endmodule

// File: rtl/bridge_pwm_chk.sv
module bridge_pwm_chk
    import bpwm_pkg::*;
#(
    parameter int PER_W  = 8,
    parameter int BASE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [3:0]        act,
    input logic [BASE_W-1:0] base,
    input logic [PER_W-1:0]  per_s,
    input bpwm_mode_e        mode_q,
    input logic              run_q
);

    p_base_bound_r2: assert property (@(posedge clk) disable iff (rst)
        base <= {per_s, 2'b11});

    p_single_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SINGLE) |=> (act[3:1] == 3'b000));

    p_pair_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(act[PIN_A] && act[PIN_B]) && !(act[PIN_C] && act[PIN_D]));

    p_fwd_legs_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FWD && run_q) |=> (act[PIN_A] && !act[PIN_B] && !act[PIN_C]));

    p_rev_legs_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_REV && run_q) |=> (act[PIN_C] && !act[PIN_A] && !act[PIN_D]));

    p_idle_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(en) && !$past(en, 2) && !$past(en, 3)) |-> (act == 4'b0000));

endmodule

bind bridge_pwm bridge_pwm_chk #(.PER_W(PER_W), .BASE_W(BASE_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .act    (act_q),
    .base   (base),
    .per_s  (per_s),
    .mode_q (mode_q),
    .run_q  (run_q)
);

// File: tb/bridge_pwm_tb.sv
`timescale 1ns/1ps
module bridge_pwm_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] period = 8'd3;
    logic [9:0] duty = 10'd0;
    logic [1:0] mode = 2'b00;
    logic [1:0] pol = 2'b00;
    logic [6:0] deadband = 7'd0;
    logic       out_a, out_b, out_c, out_d;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bridge_pwm u_dut (
        .clk(clk), .rst(rst), .en(en), .period(period), .duty(duty),
        .mode(mode), .pol(pol), .deadband(deadband),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [7:0]  per;
        logic [9:0]  dty;
        logic [6:0]  db;
        logic [1:0]  pl;
        logic [10:0] ea;
        logic [10:0] eb;
        logic [10:0] ec;
        logic [10:0] ed;
    } vec_t;

    // mode, period, duty, deadband, polarity, expected active counts A B C D
    localparam vec_t VECS [10] = '{
        '{2'b00, 8'd3, 10'd5,   7'd0, 2'b00, 11'd5,  11'd0,  11'd0,  11'd0},
        '{2'b00, 8'd3, 10'd0,   7'd0, 2'b00, 11'd0,  11'd0,  11'd0,  11'd0},
        '{2'b00, 8'd3, 10'd100, 7'd0, 2'b00, 11'd16, 11'd0,  11'd0,  11'd0},
        '{2'b01, 8'd7, 10'd12,  7'd3, 2'b00, 11'd9,  11'd17, 11'd0,  11'd0},
        '{2'b01, 8'd7, 10'd12,  7'd0, 2'b00, 11'd12, 11'd20, 11'd0,  11'd0},
        '{2'b10, 8'd4, 10'd7,   7'd2, 2'b00, 11'd20, 11'd0,  11'd0,  11'd7},
        '{2'b11, 8'd4, 10'd7,   7'd0, 2'b00, 11'd0,  11'd7,  11'd20, 11'd0},
        '{2'b01, 8'd3, 10'd0,   7'd2, 2'b00, 11'd0,  11'd16, 11'd0,  11'd0},
        '{2'b00, 8'd5, 10'd10,  7'd0, 2'b11, 11'd10, 11'd0,  11'd0,  11'd0},
        '{2'b11, 8'd2, 10'd3,   7'd0, 2'b01, 11'd0,  11'd3,  11'd12, 11'd0}
    };

    task automatic chk(input string tag, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic string tag_of(input logic [1:0] md, input logic [1:0] pl);
        if (pl != 2'b00) return "R8 polarity";
        case (md)
            2'b00:   return "R2 R3 R4 single";
            2'b01:   return "R5 half-bridge";
            2'b10:   return "R6 forward";
            default: return "R7 reverse";
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int na, nb, nc, nd, p;
        // R1: reset state with both polarity choices
        pol = 2'b00;
        repeat (4) @(negedge clk);
        chk("R1 reset pins low", {out_a, out_b, out_c, out_d}, 4'b0000);
        pol = 2'b11;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 idle pins at polarity", {out_a, out_b, out_c, out_d}, 4'b1111);

        // Table walk
        for (int v = 0; v < 10; v++) begin
            en = 1'b0;
            mode = VECS[v].md; period = VECS[v].per; duty = VECS[v].dty;
            deadband = VECS[v].db; pol = VECS[v].pl;
            repeat (4) @(negedge clk);
            en = 1'b1;
            p = 4 * (int'(VECS[v].per) + 1);
            repeat (2 * p + 8) @(negedge clk);
            na = 0; nb = 0; nc = 0; nd = 0;
            for (int k = 0; k < p; k++) begin
                na += int'(out_a ^ pol[0]);
                nb += int'(out_b ^ pol[1]);
                nc += int'(out_c ^ pol[0]);
                nd += int'(out_d ^ pol[1]);
                @(negedge clk);
            end
            chk({tag_of(VECS[v].md, VECS[v].pl), " pin A"}, na, int'(VECS[v].ea));
            chk({tag_of(VECS[v].md, VECS[v].pl), " pin B"}, nb, int'(VECS[v].eb));
            chk({tag_of(VECS[v].md, VECS[v].pl), " pin C"}, nc, int'(VECS[v].ec));
            chk({tag_of(VECS[v].md, VECS[v].pl), " pin D"}, nd, int'(VECS[v].ed));
        end

        // R9 synchronised start and R10 mode change at the boundary
        en = 1'b0;
        mode = 2'b00; period = 8'd3; duty = 10'd5; deadband = 7'd0; pol = 2'b00;
        repeat (5) @(negedge clk);
        p = 16;
        en = 1'b1;
        na = 0;
        for (int k = 0; k <= p; k++) begin
            @(negedge clk);
            na += int'(out_a);
        end
        chk("R9 no pulse in first period", na, 0);
        @(negedge clk);
        chk("R9 first pulse starts", int'(out_a), 1);
        repeat (3) @(negedge clk);
        mode = 2'b10;
        nd = 0;
        for (int k = p + 5; k <= 2 * p; k++) begin
            @(negedge clk);
            nd += int'(out_d);
        end
        chk("R10 mode held until boundary", nd, 0);
        @(negedge clk);
        chk("R10 new mode drives D", int'(out_d), 1);
        chk("R10 new mode holds A", int'(out_a), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule